// File: doc/BRIEF.md
# Duplex-Aware Flow-Control Trigger

This block sits beside one port of a network MAC and turns an asynchronous, level-style flow-control request into actions that suit the port's current duplex setting. The request is first brought into the system clock domain through a two-flop synchronizer. Edges and the held level are then taken from the synchronized copy.

When the port runs full duplex, a rising request leaves a pause command pending toward a frame generator, carrying the pause time programmed at that moment. A falling request leaves a zero-time pause command pending if the zero-pause option is on, and withdraws any unsent command if it is off. A pending command stays presented until the transmitter acknowledges it. A newer edge overwrites a command that has not been sent, and any switch of duplex mode throws the pending command away.

When the port runs half duplex, no pause commands are made. Instead, every receive-start indication seen while the synchronized request is high yields a one-cycle forced-collision pulse, which applies backpressure to the far end.

Top module: `fc_trigger`

## Requirements
- R1: While and right after reset, pause_req, pause_val and force_col are all 0.
- R2: A change on fc_req_async passes two synchronizer flops: with full_duplex held at 1, a rise set up before clock edge k shows as pause_req = 1 after edge k+2 and not earlier.
- R3: In full duplex, a synchronized rising edge makes pause_req 1 on the next cycle, and pause_val then equals the pause_time_cfg value present in the edge cycle.
- R4: In full duplex, a synchronized falling edge with zero_pause_en = 1 makes pause_req 1 with pause_val = 0; with zero_pause_en = 0 it leaves pause_req at 0, cancelling any unsent command.
- R5: A pending command keeps pause_req at 1 and pause_val unchanged until a cycle with pause_ack = 1, after which pause_req is 0 unless a new edge arrived in that cycle.
- R6: An edge that arrives while a command is pending and unacknowledged replaces it with the new command's value.
- R7: In any cycle where full_duplex differs from its value in the previous cycle, the pending command is cleared and an edge in that cycle is ignored.
- R8: force_col is 1 for exactly the cycle after each cycle with rx_start = 1, full_duplex = 0 and the synchronized request high, and 0 otherwise.
- R9: While full_duplex is 0, request edges never raise pause_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc_req_async | input | 1 | Flow-control request level, asynchronous to clk |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| zero_pause_en | input | 1 | 1 = send a zero-time pause when the request falls |
| pause_time_cfg | input | PAUSE_W (16) | Programmed pause time |
| rx_start | input | 1 | One-cycle pulse at the start of each received packet |
| pause_ack | input | 1 | Transmitter takes the pending pause command |
| pause_req | output | 1 | A pause command is pending |
| pause_val | output | PAUSE_W (16) | Pause time of the pending command |
| force_col | output | 1 | One-cycle forced-collision request |

## Verification
The hardest situations to reach from the ports are an edge that lands exactly in the cycle of an acknowledge or of a duplex switch, because the edge surfaces two cycles after the request pin moves. The bench reaches these by counting clock steps from each pin change in directed sequences, and by a long random run in which the request, duplex mode, acknowledge and receive-start pins flip independently, so coincidences occur many times while a cycle model in the bench predicts every output.

// File: rtl/fc_trig_pkg.sv
package fc_trig_pkg;

    localparam int DEF_PAUSE_W = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } fc_edge_e;

endpackage

// File: rtl/fc_req_sync.sv
module fc_req_sync
    import fc_trig_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_async,
    output logic     req_lvl,
    output fc_edge_e req_edge
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("fc_req_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], req_async};
        st_d.prev  = st_q.chain[STAGES-1];

        req_lvl  = st_q.chain[STAGES-1];
        req_edge = EDGE_NONE;
        if (st_q.chain[STAGES-1] && !st_q.prev) begin
            req_edge = EDGE_RISE;
        end else if (!st_q.chain[STAGES-1] && st_q.prev) begin
            req_edge = EDGE_FALL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fc_pause_cmd.sv
module fc_pause_cmd
    import fc_trig_pkg::*;
#(
    parameter int PAUSE_W = DEF_PAUSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  fc_edge_e           req_edge,
    input  logic               full_duplex,
    input  logic               zero_pause_en,
    input  logic [PAUSE_W-1:0] pause_time_cfg,
    input  logic               pause_ack,
    output logic               cmd_pend,
    output logic [PAUSE_W-1:0] cmd_val,
    output logic               mode_chg
);

    typedef struct packed {
        logic               pend;
        logic [PAUSE_W-1:0] val;
        logic               mode;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mode = full_duplex;
        mode_chg  = (full_duplex != st_q.mode);

        if (mode_chg) begin
            st_d.pend = 1'b0;
        end else if (full_duplex && req_edge == EDGE_RISE) begin
            st_d.pend = 1'b1;
            st_d.val  = pause_time_cfg;
        end else if (full_duplex && req_edge == EDGE_FALL) begin
            if (zero_pause_en) begin
                st_d.pend = 1'b1;
                st_d.val  = '0;
            end else begin
                st_d.pend = 1'b0;
            end
        end else if (st_q.pend && pause_ack) begin
            st_d.pend = 1'b0;
        end

        cmd_pend = st_q.pend;
        cmd_val  = st_q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fc_col_gen.sv
module fc_col_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_start,
    input  logic full_duplex,
    input  logic req_lvl,
    output logic force_col
);

    typedef struct packed {
        logic col;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.col = rx_start && !full_duplex && req_lvl;
        force_col = st_q.col;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fc_trigger.sv
module fc_trigger
    import fc_trig_pkg::*;
#(
    parameter int PAUSE_W     = DEF_PAUSE_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fc_req_async,
    input  logic               full_duplex,
    input  logic               zero_pause_en,
    input  logic [PAUSE_W-1:0] pause_time_cfg,
    input  logic               rx_start,
    input  logic               pause_ack,
    output logic               pause_req,
    output logic [PAUSE_W-1:0] pause_val,
    output logic               force_col
);

    logic     req_lvl;
    fc_edge_e req_edge;
    logic     rise_w;
    logic     fall_w;
    logic     mode_chg_w;

    fc_req_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (fc_req_async),
        .req_lvl   (req_lvl),
        .req_edge  (req_edge)
    );

    assign rise_w = (req_edge == EDGE_RISE);
    assign fall_w = (req_edge == EDGE_FALL);

    fc_pause_cmd #(
        .PAUSE_W (PAUSE_W)
    ) u_pause (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_edge       (req_edge),
        .full_duplex    (full_duplex),
        .zero_pause_en  (zero_pause_en),
        .pause_time_cfg (pause_time_cfg),
        .pause_ack      (pause_ack),
        .cmd_pend       (pause_req),
        .cmd_val        (pause_val),
        .mode_chg       (mode_chg_w)
    );

    fc_col_gen u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_start    (rx_start),
        .full_duplex (full_duplex),
        .req_lvl     (req_lvl),
        .force_col   (force_col)
    );

endmodule

// File: rtl/fc_trigger_chk.sv
module fc_trigger_chk #(
    parameter int PAUSE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               full_duplex,
    input logic               zero_pause_en,
    input logic [PAUSE_W-1:0] pause_time_cfg,
    input logic               rx_start,
    input logic               pause_ack,
    input logic               pause_req,
    input logic [PAUSE_W-1:0] pause_val,
    input logic               force_col,
    input logic               req_lvl,
    input logic               rise,
    input logic               fall,
    input logic               mode_chg
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !pause_req && !force_col);

    a_r3_rise_loads: assert property (@(posedge clk) disable iff (!rst_n)
        rise && full_duplex && !mode_chg |=> pause_req && pause_val == $past(pause_time_cfg));

    a_r4_fall_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fall && full_duplex && !mode_chg && zero_pause_en |=> pause_req && pause_val == '0);

    a_r4_fall_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        fall && full_duplex && !mode_chg && !zero_pause_en |=> !pause_req);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_ack && !rise && !fall && !mode_chg |=> pause_req && $stable(pause_val));

    a_r5_consume: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_ack && !rise && !fall && !mode_chg |=> !pause_req);

    a_r7_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !pause_req);

    a_r8_col_cause: assert property (@(posedge clk) disable iff (!rst_n)
        force_col |-> $past(rx_start) && !$past(full_duplex) && $past(req_lvl));

    a_r8_col_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start && !full_duplex && req_lvl |=> force_col);

    a_r9_half_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !full_duplex |=> !pause_req);

endmodule

bind fc_trigger fc_trigger_chk #(
    .PAUSE_W (PAUSE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .full_duplex    (full_duplex),
    .zero_pause_en  (zero_pause_en),
    .pause_time_cfg (pause_time_cfg),
    .rx_start       (rx_start),
    .pause_ack      (pause_ack),
    .pause_req      (pause_req),
    .pause_val      (pause_val),
    .force_col      (force_col),
    .req_lvl        (req_lvl),
    .rise           (rise_w),
    .fall           (fall_w),
    .mode_chg       (mode_chg_w)
);

// File: tb/test_fc_trigger.sv
`timescale 1ns/1ps
module test_fc_trigger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fc_req_async = 1'b0;
    logic        full_duplex = 1'b0;
    logic        zero_pause_en = 1'b0;
    logic [15:0] pause_time_cfg = '0;
    logic        rx_start = 1'b0;
    logic        pause_ack = 1'b0;
    logic        pause_req;
    logic [15:0] pause_val;
    logic        force_col;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // cycle model of the requirements
    bit        m1, m2, mp, mmode, mpend, mcol;
    bit [15:0] mval;

    always #10 clk = ~clk;

    fc_trigger i_fc_trigger (
        .clk            (clk),
        .rst_n          (rst_n),
        .fc_req_async   (fc_req_async),
        .full_duplex    (full_duplex),
        .zero_pause_en  (zero_pause_en),
        .pause_time_cfg (pause_time_cfg),
        .rx_start       (rx_start),
        .pause_ack      (pause_ack),
        .pause_req      (pause_req),
        .pause_val      (pause_val),
        .force_col      (force_col)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_clock(bit req, bit fd, bit zero, bit [15:0] cfg, bit rx, bit ack);
        bit rise, fall, chg;
        rise = m2 && !mp;
        fall = !m2 && mp;
        chg  = (fd != mmode);
        if (chg) mpend = 0;
        else if (fd && rise) begin mpend = 1; mval = cfg; end
        else if (fd && fall) begin
            if (zero) begin mpend = 1; mval = 16'h0; end
            else mpend = 0;
        end
        else if (mpend && ack) mpend = 0;
        mcol  = rx && !fd && m2;
        mp    = m2;
        m2    = m1;
        m1    = req;
        mmode = fd;
    endfunction

    task automatic step(input bit req, input bit fd, input bit zero,
                        input bit [15:0] cfg, input bit rx, input bit ack);
        fc_req_async   = req;
        full_duplex    = fd;
        zero_pause_en  = zero;
        pause_time_cfg = cfg;
        rx_start       = rx;
        pause_ack      = ack;
        @(posedge clk);
        model_clock(req, fd, zero, cfg, rx, ack);
        @(negedge clk);
        chk("R5 pause_req model", pause_req, mpend);
        if (mpend) chk("R3 pause_val model", pause_val, mval);
        chk("R8 force_col model", force_col, mcol);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        {m1, m2, mp, mmode, mpend, mcol} = '0;
        mval = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pause_req reset", pause_req, 0);
        chk("R1 pause_val reset", pause_val, 0);
        chk("R1 force_col reset", force_col, 0);
        rst_n = 1'b1;

        // R2/R3: latency and value capture
        repeat (4) step(0, 1, 0, 16'h1234, 0, 0);
        step(1, 1, 0, 16'h1234, 0, 0);
        step(1, 1, 0, 16'h1234, 0, 0);
        chk("R2 not yet after two edges", pause_req, 0);
        step(1, 1, 0, 16'h1234, 0, 0);
        chk("R2 pause_req on third edge", pause_req, 1);
        chk("R3 pause_val captured", pause_val, 16'h1234);
        // R5: hold until ack, value stable while cfg moves
        repeat (3) step(1, 1, 0, 16'h5555, 0, 0);
        chk("R5 still pending", pause_req, 1);
        chk("R5 value stable", pause_val, 16'h1234);
        step(1, 1, 0, 16'h5555, 0, 1);
        chk("R5 consumed by ack", pause_req, 0);

        // R4: falling with zero pause enabled
        repeat (3) step(0, 1, 1, 16'h5555, 0, 0);
        chk("R4 zero pause pending", pause_req, 1);
        chk("R4 zero pause value", pause_val, 0);
        step(0, 1, 1, 16'h5555, 0, 1);
        chk("R4 zero pause consumed", pause_req, 0);

        // R6: replace unsent command
        repeat (3) step(1, 1, 1, 16'hAAAA, 0, 0);
        chk("R6 first command", pause_val, 16'hAAAA);
        repeat (3) step(0, 1, 1, 16'hAAAA, 0, 0);
        chk("R6 replaced pending", pause_req, 1);
        chk("R6 replaced value", pause_val, 0);
        step(0, 1, 1, 16'h0, 0, 1);

        // R4: falling with zero pause disabled cancels
        repeat (3) step(1, 1, 0, 16'h0BEE, 0, 0);
        chk("R4 pending before cancel", pause_req, 1);
        repeat (3) step(0, 1, 0, 16'h0BEE, 0, 0);
        chk("R4 cancel without zero pause", pause_req, 0);

        // R7: mode change clears pending
        repeat (3) step(1, 1, 0, 16'h7777, 0, 0);
        chk("R7 pending before switch", pause_req, 1);
        step(1, 0, 0, 16'h7777, 0, 0);
        chk("R7 cleared by switch", pause_req, 0);
        // R9: edges in half duplex
        repeat (4) step(0, 0, 1, 16'h7777, 0, 0);
        chk("R9 half fall no pause", pause_req, 0);
        step(1, 0, 0, 16'h7777, 0, 0);
        step(1, 0, 0, 16'h7777, 0, 0);
        chk("R9 half before rise", pause_req, 0);
        // R7: rise coincides with switch to full duplex
        step(1, 1, 0, 16'h7777, 0, 0);
        chk("R7 edge at switch ignored", pause_req, 0);
        repeat (2) step(1, 1, 0, 16'h7777, 0, 0);
        chk("R7 edge stays ignored", pause_req, 0);

        // R8: forced collision
        step(1, 0, 0, 0, 1, 0);
        chk("R8 collision pulse", force_col, 1);
        step(1, 0, 0, 0, 0, 0);
        chk("R8 pulse one cycle", force_col, 0);
        step(1, 0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 1, 0);
        chk("R8 back-to-back pulse", force_col, 1);
        repeat (3) step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk("R8 no collision without request", force_col, 0);
        repeat (3) step(1, 1, 0, 0, 0, 1);
        step(1, 1, 0, 0, 1, 1);
        chk("R8 no collision in full duplex", force_col, 0);

        // random phase with fixed seed
        begin
            bit req, fd, zero, rx, ack;
            bit [15:0] cfg;
            int seed_dummy;
            seed_dummy = $urandom(32'h5EED_0042);
            req = 1; fd = 1; zero = 0; cfg = 16'h0100;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(7) == 0)  req  = !req;
                if ($urandom_range(63) == 0) fd   = !fd;
                if ($urandom_range(15) == 0) zero = !zero;
                cfg = 16'($urandom);
                rx  = ($urandom_range(3) == 0);
                ack = ($urandom_range(9) < 3);
                step(req, fd, zero, cfg, rx, ack);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule